// File: doc/BRIEF.md
# Bus-Stall DMA Arbiter with Halt Confirmation

This block shares the CPU bus between two DMA clients: a page copy that moves a whole 256-byte page into the sprite data port, and a one-byte sample fetch. When either client asks for the bus, the block pulls the CPU ready line low. It does not then wait a fixed worst-case time. It waits for a bus cycle in which the CPU is reading. That read shows the CPU has stopped, and the transfer can begin.

The page copy works in pairs of cycles. It reads one byte on an even bus cycle and writes that byte to the sprite port on the following odd cycle. A sample fetch that arrives while a copy is running takes the next even read slot, and the copy then continues from the same byte. A sample fetch that arrives while the bus is idle stalls the CPU for four cycles. The fetched byte is returned on a one-cycle strobe.

Top module: `bus_stall_dma`

## Requirements
- R1: A request (`copy_go` or `fetch_req` high) in a cycle where `cpu_rdy` is high makes `cpu_rdy` low in the next cycle.
- R2: After `cpu_rdy` falls, the block drives no bus cycle until a stalled cycle with `cpu_rd`=1 has been seen. Each stalled cycle with `cpu_rd`=0 lengthens the stall by one cycle.
- R3: A sample fetch requested while the bus is idle, with the CPU reading at once, holds `cpu_rdy` low for exactly 4 cycles. The read of `fetch_addr` happens in the 4th of those cycles.
- R4: `fetch_done` is high for exactly one cycle, the cycle after the fetch read, and `fetch_data` then equals the byte read at `fetch_addr`.
- R5: A page copy reads the 256 addresses `{copy_page, 8'h00}` up to `{copy_page, 8'hFF}` in ascending order. Each read is followed in the next cycle by a write (`bus_we`=1) of the same byte to address `SPR_PORT` (16'h2004).
- R6: Copy reads use only even cycles (`odd_cycle`=0) and copy writes use only odd cycles. With an immediate CPU read, a trigger on an even cycle gives a 513-cycle stall (one dummy cycle) and a trigger on an odd cycle gives a 514-cycle stall (two dummy cycles).
- R7: A sample fetch pending during a copy is served at the next even read slot. The copy then continues with the same byte index, and the stall grows by exactly 2 cycles.
- R8: Once the last copy write is done and no fetch is pending, `cpu_rdy` is high in the very next cycle.
- R9: A `copy_go` that arrives while a copy is active has no effect. A `fetch_req` that arrives while a fetch is already pending has no effect.
- R10: After reset, `cpu_rdy` is 1, and `bus_en` and `fetch_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | 1 when the CPU is doing a read in this cycle |
| odd_cycle | input | 1 | 1 on odd bus cycles, 0 on even ones |
| copy_go | input | 1 | One-cycle trigger for a page copy |
| copy_page | input | 8 | Source page number for the copy |
| fetch_req | input | 1 | One-cycle request for a sample fetch |
| fetch_addr | input | 16 | Address of the byte to fetch |
| bus_rdata | input | 8 | Bus read data, valid in the same cycle as the address |
| bus_en | output | 1 | The block drives the bus in this cycle |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| cpu_rdy | output | 1 | CPU ready line; low stalls the CPU |
| fetch_done | output | 1 | One-cycle strobe that marks a completed fetch |
| fetch_data | output | 8 | Fetched byte, valid while `fetch_done` is high |

## Verification
Counting from the trigger in cycle t, `cpu_rdy` drops at t+1. An idle fetch reads its address at t+4+d, where d is the number of stalled non-read cycles, and strobes `fetch_done` one cycle after that read. A copy stall lasts (1+d) + align + 512 + 2·fetches cycles, where align is 1 when the halt-confirming cycle is even. The bench runs each job cycle by cycle. It drives inputs and samples outputs at the falling edge, so each result is read in the exact cycle it is due. It compares stall length, read/write parity, every written byte, and the fetch strobe cycle against values that its own functions compute.

// File: rtl/dmab_pkg.sv
// Package: shared types for the bus-stall DMA arbiter.
// Assumes: one bus cycle per clock.
package dmab_pkg;

    // Sequencer state
    typedef enum logic [2:0] {
        ST_IDLE,   // CPU runs, ready high
        ST_HALT,   // ready low, waiting for a CPU read
        ST_PRE1,   // first dummy of an idle fetch
        ST_PRE2,   // second dummy of an idle fetch
        ST_FRD,    // fetch read outside of a copy
        ST_COPY    // page copy running
    } dmab_state_t;

    // Bus operation issued in the current cycle
    typedef enum logic [1:0] {
        OP_NONE,
        OP_FETCH,
        OP_CRD,
        OP_CWR
    } dmab_op_t;

endpackage

// File: rtl/dmab_req_latch.sv
// Request latch: holds the active copy with its page, and one pending
// sample fetch with its address.
// Assumes: the sequencer clears each request with a one-cycle strobe.
// New requests are dropped while a request of the same kind is held.
module dmab_req_latch #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              copy_go,
    input  logic [PAGE_W-1:0] copy_page,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_take,
    input  logic              copy_end,
    output logic              copy_act,
    output logic [PAGE_W-1:0] page_q,
    output logic              fetch_pend,
    output logic [ADDR_W-1:0] faddr_q
);

    // Copy request: take a trigger only when no copy is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_act <= 1'b0;
            page_q   <= '0;
        end else if (copy_end) begin
            copy_act <= 1'b0;
        end else if (copy_go && !copy_act) begin
            copy_act <= 1'b1;
            page_q   <= copy_page;
        end
    end

    // Fetch request: one pending slot, cleared when it is served
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pend <= 1'b0;
            faddr_q    <= '0;
        end else if (fetch_take) begin
            fetch_pend <= 1'b0;
        end else if (fetch_req && !fetch_pend) begin
            fetch_pend <= 1'b1;
            faddr_q    <= fetch_addr;
        end
    end

endmodule

// File: rtl/dmab_sequencer.sv
// Sequencer: stalls the CPU, waits for a CPU read as proof of halt,
// then issues one bus operation per cycle. Copy reads go on even
// cycles and copy writes on odd ones, and a pending fetch takes a
// read slot.
// Assumes: odd_cycle toggles every cycle.
module dmab_sequencer
    import dmab_pkg::*;
#(
    parameter int COPY_LEN = 256,
    parameter int CNT_W    = $clog2(COPY_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_rd,
    input  logic             odd_cycle,
    input  logic             start,
    input  logic             copy_act,
    input  logic             fetch_pend,
    output dmab_op_t         op,
    output logic             rdy,
    output logic             copy_end,
    output logic             fetch_take,
    output logic [CNT_W-1:0] idx
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(COPY_LEN - 1);

    dmab_state_t st, st_nx;
    logic        have;

    // Next state and this cycle's bus operation
    always_comb begin
        st_nx = st;
        op    = OP_NONE;
        unique case (st)
            ST_IDLE: if (start || copy_act || fetch_pend) st_nx = ST_HALT;
            ST_HALT: if (cpu_rd) st_nx = copy_act ? ST_COPY : ST_PRE1;
            ST_PRE1: st_nx = ST_PRE2;
            ST_PRE2: st_nx = ST_FRD;
            ST_FRD: begin
                op    = OP_FETCH;
                st_nx = copy_act ? ST_COPY : ST_IDLE;
            end
            ST_COPY: begin
                if (!odd_cycle) begin
                    op = fetch_pend ? OP_FETCH : OP_CRD;
                end else if (have) begin
                    op = OP_CWR;
                    if (idx == LAST_IDX) st_nx = fetch_pend ? ST_FRD : ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    assign rdy        = (st == ST_IDLE);
    assign fetch_take = (op == OP_FETCH);
    assign copy_end   = (op == OP_CWR) && (idx == LAST_IDX);

    // State, byte-in-hand flag and byte index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            have <= 1'b0;
            idx  <= '0;
        end else begin
            st <= st_nx;
            if (op == OP_CRD)      have <= 1'b1;
            else if (op == OP_CWR) have <= 1'b0;
            if (op == OP_CWR)      idx  <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/dmab_bus_mux.sv
// Bus driver: turns the sequencer operation into address, data and
// write enable, holds the copied byte between its read and its write,
// and returns the fetched byte.
// Assumes: bus_rdata is valid in the same cycle as the read address.
module dmab_bus_mux
    import dmab_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter int                CNT_W    = 8,
    parameter int                PAGE_W   = 8,
    parameter logic [ADDR_W-1:0] SPR_PORT = 16'h2004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dmab_op_t          op,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [CNT_W-1:0]  idx,
    input  logic [ADDR_W-1:0] faddr_q,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_en,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              fetch_done,
    output logic [DATA_W-1:0] fetch_data
);

    logic [DATA_W-1:0] hold;

    // Address, write enable and data for this cycle
    always_comb begin
        bus_en    = (op != OP_NONE);
        bus_we    = (op == OP_CWR);
        bus_wdata = (op == OP_CWR) ? hold : '0;
        unique case (op)
            OP_FETCH: bus_addr = faddr_q;
            OP_CRD:   bus_addr = {page_q, idx};
            OP_CWR:   bus_addr = SPR_PORT;
            default:  bus_addr = '0;
        endcase
    end

    // Capture the copy byte, and the fetch byte with its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold       <= '0;
            fetch_done <= 1'b0;
            fetch_data <= '0;
        end else begin
            fetch_done <= (op == OP_FETCH);
            if (op == OP_CRD)   hold       <= bus_rdata;
            if (op == OP_FETCH) fetch_data <= bus_rdata;
        end
    end

endmodule

// File: rtl/bus_stall_dma.sv
// Top: bus-stall DMA arbiter for a page copy and a sample fetch.
// Assumes: the CPU stops at its next read while ready is low.
module bus_stall_dma #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int COPY_LEN = 256,
    parameter int CNT_W    = $clog2(COPY_LEN),
    parameter int PAGE_W   = ADDR_W - CNT_W,
    parameter logic [ADDR_W-1:0] SPR_PORT = 16'h2004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              odd_cycle,
    input  logic              copy_go,
    input  logic [PAGE_W-1:0] copy_page,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_en,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              cpu_rdy,
    output logic              fetch_done,
    output logic [DATA_W-1:0] fetch_data
);

    import dmab_pkg::*;

    logic              copy_act, fetch_pend, fetch_take, copy_end;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] faddr_q;
    logic [CNT_W-1:0]  idx;
    dmab_op_t          op;

    dmab_req_latch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .copy_go(copy_go), .copy_page(copy_page),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_take(fetch_take), .copy_end(copy_end),
        .copy_act(copy_act), .page_q(page_q),
        .fetch_pend(fetch_pend), .faddr_q(faddr_q)
    );

    dmab_sequencer #(.COPY_LEN(COPY_LEN), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd(cpu_rd), .odd_cycle(odd_cycle),
        .start(copy_go || fetch_req),
        .copy_act(copy_act), .fetch_pend(fetch_pend),
        .op(op), .rdy(cpu_rdy), .copy_end(copy_end),
        .fetch_take(fetch_take), .idx(idx)
    );

    dmab_bus_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .PAGE_W(PAGE_W), .SPR_PORT(SPR_PORT)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .op(op), .page_q(page_q), .idx(idx), .faddr_q(faddr_q),
        .bus_rdata(bus_rdata),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata),
        .fetch_done(fetch_done), .fetch_data(fetch_data)
    );

endmodule

// File: rtl/dmab_chk.sv
// Checker: port-level properties of the bus-stall DMA arbiter.
module dmab_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SPR_PORT = 16'h2004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              copy_go,
    input logic              fetch_req,
    input logic              odd_cycle,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cpu_rdy,
    input logic              fetch_done
);

    // R1
    rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdy && (copy_go || fetch_req)) |=> !cpu_rdy);

    // R2
    halt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rdy) |-> !bus_en);

    // R2
    bus_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> (!cpu_rdy && !$past(cpu_rdy)));

    // R4
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> $past(bus_en && !bus_we));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !fetch_done);

    // R5
    write_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we) |-> (bus_addr == SPR_PORT && $past(bus_en && !bus_we)));

    // R6
    write_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we) |-> odd_cycle);

endmodule

bind bus_stall_dma dmab_chk #(.ADDR_W(ADDR_W), .SPR_PORT(SPR_PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .copy_go(copy_go), .fetch_req(fetch_req),
    .odd_cycle(odd_cycle), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .cpu_rdy(cpu_rdy), .fetch_done(fetch_done)
);

// File: tb/sim_bus_stall_dma.sv
// Bench: directed and seeded random jobs, checked cycle by cycle.
module sim_bus_stall_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b1;
    logic        odd_cycle;
    logic        copy_go = 1'b0;
    logic [7:0]  copy_page = '0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic [7:0]  bus_rdata;
    logic        bus_en, bus_we, cpu_rdy, fetch_done;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, fetch_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    // Memory model: the byte stored at each address
    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    assign bus_rdata = mem_val(bus_addr);

    always @(posedge clk) begin
        if (!rst_n) odd_cycle <= 1'b0;
        else        odd_cycle <= ~odd_cycle;
    end

    bus_stall_dma u0 (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .odd_cycle(odd_cycle),
        .copy_go(copy_go), .copy_page(copy_page),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .bus_rdata(bus_rdata), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cpu_rdy(cpu_rdy),
        .fetch_done(fetch_done), .fetch_data(fetch_data)
    );

    // Watchdog: ends a hung run as a failure
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d exp<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Expected stall length of a copy job
    function automatic int exp_copy_low(input bit trig_odd, input int dly, input bit with_fetch);
        bit conf_odd;
        conf_odd = trig_odd ^ bit'((1 + dly) & 1);
        return (1 + dly) + (conf_odd ? 0 : 1) + 512 + (with_fetch ? 2 : 0);
    endfunction

    // Run one job: trigger, drive cpu_rd, observe each cycle at negedge
    task automatic run_job(input bit want_copy, input logic [7:0] pg, input bit want_fetch,
                           input logic [15:0] fa, input int foff, input int dly,
                           input bit trig_odd, input int go_off);
        int low = 0, wr = 0, h = 0, fread_k = -1, fdone_k = -1, fdone_n = 0;
        int rose_k = -1, last_wr_k = -1, wr_bad = 0, rd_bad = 0, halt_bad = 0, fd_bad = 0;
        int exp_low;
        bit seen_rd = 1'b0;
        @(negedge clk);
        while (odd_cycle != trig_odd) @(negedge clk);
        if (want_copy) begin copy_go = 1'b1; copy_page = pg; end
        else begin fetch_req = 1'b1; fetch_addr = fa; end
        for (int k = 1; k < 700; k++) begin
            @(negedge clk);
            copy_go = 1'b0;
            fetch_req = 1'b0;
            if (want_fetch && k == foff) begin
                fetch_req = 1'b1;
                fetch_addr = want_copy ? fa : (fa ^ 16'h0100);
            end
            if (want_copy && k == go_off) begin copy_go = 1'b1; copy_page = pg + 8'd1; end
            if (k == 1 && cpu_rdy) chk(1'b0, "R1 ready low after request", 1, 0);
            if (bus_en && !seen_rd) halt_bad++;
            if (!cpu_rdy) begin
                low++;
                if (!seen_rd) begin
                    if (h < dly) begin cpu_rd = 1'b0; h++; end
                    else begin cpu_rd = 1'b1; seen_rd = 1'b1; end
                end
            end else cpu_rd = 1'b1;
            if (bus_en && bus_we) begin
                if (bus_addr != 16'h2004 || bus_wdata != mem_val({pg, wr[7:0]}) || !odd_cycle)
                    wr_bad++;
                wr++;
                last_wr_k = k;
            end
            if (bus_en && !bus_we) begin
                if (bus_addr == fa) fread_k = k;
                else if (bus_addr != {pg, wr[7:0]} || odd_cycle) rd_bad++;
            end
            if (fetch_done) begin
                fdone_n++;
                fdone_k = k;
                if (fetch_data != mem_val(fa)) fd_bad++;
            end
            if (cpu_rdy && low > 0 && rose_k < 0) rose_k = k;
            if (rose_k >= 0 && k > rose_k + 2) break;
        end
        chk(halt_bad == 0, "R2 no bus cycle before halt read", halt_bad, 0);
        if (want_copy) begin
            exp_low = exp_copy_low(trig_odd, dly, want_fetch);
            chk(low == exp_low, "R6/R7 copy stall length", low, exp_low);
            chk(wr == 256, "R5/R9 bytes written", wr, 256);
            chk(wr_bad == 0, "R5 write data/port/parity", wr_bad, 0);
            chk(rd_bad == 0, "R6 copy read address/parity", rd_bad, 0);
            chk(last_wr_k == rose_k - 1, "R8 ready rises after last write", rose_k, last_wr_k + 1);
        end else begin
            exp_low = 4 + dly;
            chk(low == exp_low, "R3 idle fetch stall length", low, exp_low);
            chk(fread_k == exp_low, "R3 fetch read cycle", fread_k, exp_low);
            chk(rd_bad == 0, "R9 duplicate fetch ignored", rd_bad, 0);
        end
        if (want_fetch || !want_copy) begin
            chk(fdone_n == 1, "R4/R9 single fetch strobe", fdone_n, 1);
            chk(fdone_k == fread_k + 1, "R4 strobe cycle", fdone_k, fread_k + 1);
            chk(fd_bad == 0, "R4 fetch data", fd_bad, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cpu_rdy == 1'b1, "R10 ready after reset", int'(cpu_rdy), 1);
        chk(bus_en == 1'b0, "R10 bus idle after reset", int'(bus_en), 0);
        chk(fetch_done == 1'b0, "R10 no strobe after reset", int'(fetch_done), 0);

        // Directed corners
        run_job(1'b0, 8'h00, 1'b0, 16'hC123, 0, 0, 1'b0, -1);   // R3 idle fetch
        run_job(1'b0, 8'h00, 1'b1, 16'hC456, 2, 3, 1'b1, -1);   // R2, R9 slow halt, dup fetch
        run_job(1'b1, 8'h12, 1'b0, 16'hC000, 0, 0, 1'b0, -1);   // R6 even trigger: 513
        run_job(1'b1, 8'h34, 1'b0, 16'hC000, 0, 0, 1'b1, -1);   // R6 odd trigger: 514
        run_job(1'b1, 8'h56, 1'b1, 16'hD0F0, 101, 0, 1'b0, 200); // R7, R9
        run_job(1'b1, 8'h07, 1'b1, 16'hE00A, 2, 2, 1'b1, -1);   // R7 fetch during halt

        // Seeded random jobs
        for (int i = 0; i < 10; i++) begin
            bit        c, f, p;
            int        d, o;
            logic [7:0]  pg;
            logic [15:0] fa;
            c  = ($urandom_range(0, 3) != 0);
            f  = $urandom_range(0, 1) == 1;
            p  = $urandom_range(0, 1) == 1;
            d  = $urandom_range(0, 3);
            o  = $urandom_range(2, 450);
            pg = 8'($urandom_range(0, 127));
            fa = {2'b11, 14'($urandom_range(0, 16383))};
            run_job(c, pg, f, fa, c ? o : 2, d, p, -1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule